// File: doc/BRIEF.md
# Codec reset and startup sequencer

This block decides when a multichannel audio converter may leave reset and when each of its two signal paths, playback (DAC) and capture (ADC), may begin its fade-in. It runs on the system clock. It watches a power-good level, an active-low reset pin and the two frame clocks. It keeps an internal reset asserted until the reset pin has been high for a fixed number of system-clock cycles while both frame clocks stay locked to the system clock.

Once the internal reset drops, each path counts its own frame periods. The length of that delay is scaled by the sampling-rate mode, which is captured at the moment of release. When its delay ends, a path gives a one-cycle fade-start strobe and raises its running flag. Losing lock on either frame clock, or pulling the pin low, returns the whole block to reset. When the cause goes away, the complete sequence runs again from the start.

Top module: `codec_reset_seq`

## Requirements
- R1: While `powerGood` is low, `internalReset` is high, both running flags are low and neither fade strobe fires.
- R2: With both frame clocks locked, `internalReset` falls exactly `POR_CYCLES`+3 rising clock edges after `rstPinN` rises. The 3 extra edges are two synchronizer stages plus one state update.
- R3: A frame clock counts as locked only while each period between its rising edges measures `FRAME_RATIO`±1 system-clock cycles. A wrong period, or no edge within `FRAME_RATIO`+1 cycles, asserts `internalReset` and clears both running flags.
- R4: When lock returns, the full power-on count is repeated before `internalReset` falls again.
- R5: After release, the DAC path waits `DAC_BASE`, 2×`DAC_BASE` or 4×`DAC_BASE` DAC frame periods before its fade strobe, for `rateMode` 0 (single), 1 (dual) and 2 or 3 (quad).
- R6: After release, the ADC path waits `ADC_BASE` or 2×`ADC_BASE` ADC frame periods for `rateMode` 0 or 1. With `rateMode` 2 or 3 the ADC path never starts.
- R7: Each fade strobe is high for exactly one cycle. The matching running flag rises with it and stays high until the block is reset.
- R8: `rstPinN` going low asserts `internalReset` within 3 clock edges and clears both running flags within 4. Raising it again repeats the R2 sequence.
- R9: `rateMode` is captured when `internalReset` falls. Later changes do not alter the path delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| powerGood | input | 1 | Power detected; low acts as asynchronous block reset |
| rstPinN | input | 1 | External reset pin, active low, asynchronous |
| dacFrameClk | input | 1 | DAC frame clock |
| adcFrameClk | input | 1 | ADC frame clock |
| rateMode | input | 2 | 0 single, 1 dual, 2 or 3 quad |
| internalReset | output | 1 | Internal reset and power-down for the converter |
| dacStartFade | output | 1 | One-cycle strobe that starts the DAC fade-in |
| adcStartFade | output | 1 | One-cycle strobe that starts the ADC fade-in |
| dacRunning | output | 1 | DAC path in normal operation |
| adcRunning | output | 1 | ADC path in normal operation |

## Verification
The assertions assume that both frame clocks are derived from the system clock, so that a frame edge travels through the two sampling flops before it is counted. They also assume `rateMode` is steady during the cycle in which the internal reset drops. The stimulus meets these assumptions in two ways. All frame clocks are generated from a counter on the falling system-clock edge, and every change to the pin, the rate and the power-good level is made on that same falling edge. Loss of lock is produced deliberately, either by shortening one frame period or by stopping one frame clock. Both of these are legal conditions that the monitor must detect.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_POR  = 2'd1,
    ST_RUN  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic clearAll;   // wipe counters and running flags
    logic porEn;      // advance the power-on counter
    logic latchRate;  // capture rateMode on release
    logic pathRun;    // path delay counters may advance
  } seqStrobe_t;
endpackage

// File: rtl/seqFrameLock.sv
module seqFrameLock #(
  parameter int FRAME_RATIO = 256
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameIn,
  output logic frameEdge,
  output logic locked
);
  localparam int CW = $clog2(FRAME_RATIO + 3);
  localparam logic [CW-1:0] LO_CNT  = CW'(FRAME_RATIO - 2);
  localparam logic [CW-1:0] HI_CNT  = CW'(FRAME_RATIO);
  localparam logic [CW-1:0] TMO_CNT = CW'(FRAME_RATIO + 1);

  logic meta, syncQ, prevQ, seenEdge;
  logic [CW-1:0] cnt;

  assign frameEdge = syncQ & ~prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= 1'b0; syncQ <= 1'b0; prevQ <= 1'b0;
    end else begin
      meta <= frameIn; syncQ <= meta; prevQ <= syncQ;
    end
  end

  // cnt holds cycles since the last edge minus one; period = cnt + 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0; seenEdge <= 1'b0; locked <= 1'b0;
    end else if (frameEdge) begin
      cnt <= '0;
      seenEdge <= 1'b1;
      if (seenEdge) locked <= (cnt >= LO_CNT) && (cnt <= HI_CNT);
    end else if (cnt == TMO_CNT) begin
      locked <= 1'b0;
      seenEdge <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_timeout_unlock_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == TMO_CNT && !frameEdge) |=> !locked);
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath import codec_seq_pkg::*; #(
  parameter int POR_CYCLES  = 3846,
  parameter int FRAME_RATIO = 256,
  parameter int DAC_BASE    = 3600,
  parameter int ADC_BASE    = 4800
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rstPinN,
  input  logic       dacFrameClk,
  input  logic       adcFrameClk,
  input  logic [1:0] rateMode,
  input  seqStrobe_t strobe,
  output logic       pinHigh,
  output logic       clocksOk,
  output logic       porDone,
  output logic [1:0] startFade,  // [0] DAC, [1] ADC
  output logic [1:0] running
);
  localparam int NPATH = 2;
  localparam int PW = $clog2(POR_CYCLES + 1);
  localparam int MAXT = (DAC_BASE * 4 > ADC_BASE * 2) ? DAC_BASE * 4 : ADC_BASE * 2;
  localparam int DW = $clog2(MAXT + 1);

  logic pinMeta;
  logic [PW-1:0] porCnt;
  logic [1:0] rateHeld;
  logic [NPATH-1:0] frameVec, frameEdge, lockVec, pathEnable;
  logic [DW-1:0] pathTarget [NPATH];
  logic [1:0] dacShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinMeta <= 1'b0; pinHigh <= 1'b0;
    end else begin
      pinMeta <= rstPinN; pinHigh <= pinMeta;
    end
  end

  assign frameVec = {adcFrameClk, dacFrameClk};
  assign clocksOk = &lockVec;

  for (genvar g = 0; g < NPATH; g++) begin : gLock
    seqFrameLock #(.FRAME_RATIO(FRAME_RATIO)) uLock (
      .clk(clk), .rstN(rstN), .frameIn(frameVec[g]),
      .frameEdge(frameEdge[g]), .locked(lockVec[g]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             porCnt <= '0;
    else if (strobe.porEn) porCnt <= porCnt + 1'b1;
    else                   porCnt <= '0;
  end
  assign porDone = (porCnt == PW'(POR_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rateHeld <= 2'd0;
    else if (strobe.latchRate) rateHeld <= rateMode;
  end

  always_comb begin
    dacShift = rateHeld[1] ? 2'd2 : {1'b0, rateHeld[0]};
    pathTarget[0] = DW'(DAC_BASE) << dacShift;
    pathTarget[1] = DW'(ADC_BASE) << rateHeld[0];
    pathEnable = {~rateHeld[1], 1'b1};
  end

  for (genvar p = 0; p < NPATH; p++) begin : gPath
    logic [DW-1:0] frameCnt;
    logic fadeQ, runQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        frameCnt <= '0; fadeQ <= 1'b0; runQ <= 1'b0;
      end else if (strobe.clearAll) begin
        frameCnt <= '0; fadeQ <= 1'b0; runQ <= 1'b0;
      end else begin
        fadeQ <= 1'b0;
        if (strobe.pathRun && pathEnable[p] && !runQ && frameEdge[p]) begin
          if (frameCnt == pathTarget[p] - DW'(1)) begin
            fadeQ <= 1'b1; runQ <= 1'b1;
          end else begin
            frameCnt <= frameCnt + 1'b1;
          end
        end
      end
    end
    assign startFade[p] = fadeQ;
    assign running[p]   = runQ;

    assert_fade_single_R7: assert property (@(posedge clk) disable iff (!rstN)
      fadeQ |=> !fadeQ);
    assert_run_with_fade_R7: assert property (@(posedge clk) disable iff (!rstN)
      $rose(runQ) |-> fadeQ);
  end

  assert_adc_quad_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    rateHeld[1] |-> !startFade[1]);
  assert_clear_running_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (running == 2'b00));
endmodule

// File: rtl/seqControl.sv
module seqControl import codec_seq_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinHigh,
  input  logic       clocksOk,
  input  logic       porDone,
  output seqStrobe_t strobe,
  output logic       internalReset
);
  seqState_t state, stateNext;
  logic goodIn;

  assign goodIn = pinHigh & clocksOk;

  always_comb begin
    stateNext = state;
    if (!goodIn) stateNext = ST_HOLD;
    else begin
      case (state)
        ST_HOLD: stateNext = ST_POR;
        ST_POR:  if (porDone) stateNext = ST_RUN;
        ST_RUN:  stateNext = ST_RUN;
        default: stateNext = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.clearAll  = (state == ST_HOLD);
    strobe.porEn     = (state == ST_POR);
    strobe.latchRate = (state == ST_POR) && porDone && goodIn;
    strobe.pathRun   = (state == ST_RUN) && goodIn;
  end
  assign internalReset = (state != ST_RUN);

  assert_unlock_resets_R3: assert property (@(posedge clk) disable iff (!rstN)
    !clocksOk |=> internalReset);
  assert_pin_low_resets_R8: assert property (@(posedge clk) disable iff (!rstN)
    !pinHigh |=> internalReset);
  assert_release_after_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(internalReset) |-> $past(porDone));
endmodule

// File: rtl/codec_reset_seq.sv
module codec_reset_seq import codec_seq_pkg::*; #(
  parameter int POR_CYCLES  = 3846,
  parameter int FRAME_RATIO = 256,
  parameter int DAC_BASE    = 3600,
  parameter int ADC_BASE    = 4800
) (
  input  logic       clk,
  input  logic       powerGood,
  input  logic       rstPinN,
  input  logic       dacFrameClk,
  input  logic       adcFrameClk,
  input  logic [1:0] rateMode,
  output logic       internalReset,
  output logic       dacStartFade,
  output logic       adcStartFade,
  output logic       dacRunning,
  output logic       adcRunning
);
  seqStrobe_t strobe;
  logic pinHigh, clocksOk, porDone;
  logic [1:0] startFade, running;

  seqControl uCtrl (
    .clk(clk), .rstN(powerGood), .pinHigh(pinHigh), .clocksOk(clocksOk),
    .porDone(porDone), .strobe(strobe), .internalReset(internalReset));

  seqDatapath #(
    .POR_CYCLES(POR_CYCLES), .FRAME_RATIO(FRAME_RATIO),
    .DAC_BASE(DAC_BASE), .ADC_BASE(ADC_BASE)
  ) uData (
    .clk(clk), .rstN(powerGood), .rstPinN(rstPinN),
    .dacFrameClk(dacFrameClk), .adcFrameClk(adcFrameClk),
    .rateMode(rateMode), .strobe(strobe), .pinHigh(pinHigh),
    .clocksOk(clocksOk), .porDone(porDone),
    .startFade(startFade), .running(running));

  assign dacStartFade = startFade[0];
  assign adcStartFade = startFade[1];
  assign dacRunning   = running[0];
  assign adcRunning   = running[1];
endmodule

// File: tb/codec_reset_seq_tb.sv
module codec_reset_seq_tb;
  localparam int POR = 40;
  localparam int RATIO = 8;
  localparam int DB = 6;
  localparam int AB = 8;

  logic clk = 1'b0;
  logic powerGood = 1'b0, rstPinN = 1'b0;
  logic dacFrame = 1'b0, adcFrame = 1'b0;
  logic [1:0] rateMode = 2'd0;
  logic internalReset, dacStartFade, adcStartFade, dacRunning, adcRunning;

  int checks = 0, errors = 0;
  int dacHalf = RATIO / 2, adcHalf = RATIO / 2;
  bit dacEn = 1'b1, adcEn = 1'b1;
  int dacPh = 0, adcPh = 0, dacRise = 0, adcRise = 0;

  always #4 clk = ~clk;

  codec_reset_seq #(.POR_CYCLES(POR), .FRAME_RATIO(RATIO), .DAC_BASE(DB), .ADC_BASE(AB)) u_dut (
    .clk(clk), .powerGood(powerGood), .rstPinN(rstPinN),
    .dacFrameClk(dacFrame), .adcFrameClk(adcFrame), .rateMode(rateMode),
    .internalReset(internalReset), .dacStartFade(dacStartFade),
    .adcStartFade(adcStartFade), .dacRunning(dacRunning), .adcRunning(adcRunning));

  always @(negedge clk) begin
    if (dacEn) begin
      if (dacPh >= dacHalf - 1) begin
        dacPh <= 0; dacFrame <= ~dacFrame;
        if (!dacFrame) dacRise <= dacRise + 1;
      end else dacPh <= dacPh + 1;
    end
    if (adcEn) begin
      if (adcPh >= adcHalf - 1) begin
        adcPh <= 0; adcFrame <= ~adcFrame;
        if (!adcFrame) adcRise <= adcRise + 1;
      end else adcPh <= adcPh + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  // pin low, set rate, raise pin, time the release, then watch both paths
  task automatic runStartup(input logic [1:0] rate, input int expDac, input int expAdc,
                            input bit bumpRate, input string req);
    int edges, d0, a0, dacGot, adcGot, dacHi, adcHi;
    @(negedge clk); rstPinN = 1'b0;
    tick(6);
    rateMode = rate;
    @(negedge clk); rstPinN = 1'b1;
    edges = 0;
    do begin @(negedge clk); #1; edges++; end while (internalReset && edges < POR + 60);
    check(edges == POR + 3, "R2", "release edges", edges, POR + 3);
    d0 = dacRise; a0 = adcRise;
    if (bumpRate) rateMode = (rate == 2'd0) ? 2'd2 : 2'd0;  // R9: ignored after latch
    dacGot = -1; adcGot = -1; dacHi = 0; adcHi = 0;
    for (int c = 0; c < 60 * RATIO; c++) begin
      @(negedge clk); #1;
      if (dacStartFade) begin dacHi++; if (dacGot < 0) dacGot = dacRise - d0; end
      if (adcStartFade) begin adcHi++; if (adcGot < 0) adcGot = adcRise - a0; end
    end
    check(dacGot >= expDac - 1 && dacGot <= expDac + 1, req, "DAC delay frames", dacGot, expDac);
    check(dacHi == 1, "R7", "DAC strobe width", dacHi, 1);
    check(dacRunning == 1'b1, "R7", "DAC running held", dacRunning, 1);
    if (expAdc < 0) begin
      check(adcHi == 0 && !adcRunning, "R6", "ADC quad idle", adcHi, 0);
    end else begin
      check(adcGot >= expAdc - 1 && adcGot <= expAdc + 1, req, "ADC delay frames", adcGot, expAdc);
      check(adcHi == 1 && adcRunning, "R7", "ADC strobe and running", adcHi, 1);
    end
  endtask

  task automatic testPowerOff();  // R1
    tick(5);
    check(internalReset === 1'b1, "R1", "internalReset off", internalReset, 1);
    check(!dacRunning && !adcRunning, "R1", "running off", {dacRunning, adcRunning}, 0);
    check(!dacStartFade && !adcStartFade, "R1", "fade off", {dacStartFade, adcStartFade}, 0);
    @(negedge clk); powerGood = 1'b1;
    tick(40);
  endtask

  task automatic testPinDrop();  // R8
    int edges;
    @(negedge clk); rstPinN = 1'b0;
    edges = 0;
    do begin @(negedge clk); #1; edges++; end while (!internalReset && edges < 20);
    check(edges <= 3, "R8", "reset assert edges", edges, 3);
    tick(1);
    check(!dacRunning && !adcRunning, "R8", "running cleared", {dacRunning, adcRunning}, 0);
  endtask

  task automatic testSyncLoss();  // R3, R4
    int edges;
    dacHalf = 3;
    tick(4 * RATIO);
    check(internalReset === 1'b1, "R3", "reset on bad period", internalReset, 1);
    check(!dacRunning && !adcRunning, "R3", "running cleared on bad period",
          {dacRunning, adcRunning}, 0);
    dacHalf = RATIO / 2;
    edges = 0;
    do begin @(negedge clk); #1; edges++; end while (internalReset && edges < POR + 100);
    check(edges >= POR + 1 && edges <= POR + 5 * RATIO, "R4", "relock release edges", edges, POR);
    tick(40 * RATIO);
    adcEn = 1'b0;
    tick(3 * RATIO);
    check(internalReset === 1'b1, "R3", "reset on stopped clock", internalReset, 1);
    check(!dacRunning, "R3", "DAC cleared on stopped ADC clock", dacRunning, 0);
    adcEn = 1'b1;
    tick(4 * RATIO);
  endtask

  initial begin
    testPowerOff();
    runStartup(2'd0, DB, AB, 1'b0, "R5");
    testPinDrop();
    runStartup(2'd1, 2 * DB, 2 * AB, 1'b0, "R6");
    runStartup(2'd2, 4 * DB, -1, 1'b0, "R5");
    runStartup(2'd3, 4 * DB, -1, 1'b0, "R6");
    runStartup(2'd1, 2 * DB, 2 * AB, 1'b1, "R9");
    testSyncLoss();
    runStartup(2'd0, DB, AB, 1'b1, "R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule